// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell with Double-Rate Paths

This block models one programmable I/O cell sitting between a chip pin and the core logic. It has three paths. The output path takes two data lines from the core and drives them to the pin. The enable path takes two enable lines and decides whether the pin is driven or left floating. The input path returns the pin value to the core.

The output and enable paths are each built at elaboration time in one of three forms. The direct form passes the first line straight through. The single-register form launches the first line from a rising-edge register. The double-rate form captures both lines on the rising edge and sends the first during the high phase of the clock and the second during the low phase. The input path always offers a combinational copy of the pin, plus one copy registered on the rising edge and one on the falling edge of its own clock. A parameter mask can invert every control and data line that enters the cell, clocks included.

Top module: `bidir_ddr_cell`

## Requirements
- R1: With `OUT_MODE` = 0 (direct), the driven pin level equals `dout_a` combinationally.
- R2: With `OUT_MODE` = 1 (single register), the driven pin level is the `dout_a` value captured at the last rising `clk_out` edge with `ce` high.
- R3: With `OUT_MODE` = 2 (double rate), both `dout_a` and `dout_b` are captured on the rising `clk_out` edge. The captured `dout_a` is driven while `clk_out` is high and the captured `dout_b` while it is low.
- R4: When the selected enable level is 1, the cell does not drive `pad`, so an external driver sets its level. When it is 0, the cell drives `pad` with the selected output level.
- R5: `OE_MODE` offers the same three forms (0 direct from `oe_a`, 1 registered `oe_a`, 2 double rate from `oe_a`/`oe_b`), and the forms use the same capture and phase rules as the output path.
- R6: `din_direct` follows `pad` combinationally. `din_rise` captures `pad` on the rising `clk_in` edge and `din_fall` captures it on the falling edge.
- R7: While `ce` is low, no storage element of the cell changes.
- R8: `rst` is asynchronous and active high. It clears the output and input registers to 0 and sets the enable registers to 1, so the pin floats in any registered enable form.
- R9: `INV_MASK` bit positions invert incoming lines as follows: bit 0 `dout_a`, 1 `dout_b`, 2 `oe_a`, 3 `oe_b`, 4 `clk_out`, 5 `clk_in`, 6 `ce`, 7 `rst`. With every line inverted and every input pre-inverted, the cell behaves exactly as an uninverted cell does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_out | input | 1 | Clock for the output and enable storage |
| clk_in | input | 1 | Clock for the input storage |
| ce | input | 1 | Clock enable for all storage elements |
| rst | input | 1 | Asynchronous reset |
| dout_a | input | 1 | First output data line |
| dout_b | input | 1 | Second output data line (double rate only) |
| oe_a | input | 1 | First enable line, 1 = float |
| oe_b | input | 1 | Second enable line (double rate only) |
| pad | inout | 1 | Bidirectional pin |
| din_direct | output | 1 | Combinational copy of the pin |
| din_rise | output | 1 | Pin value captured on the rising input clock edge |
| din_fall | output | 1 | Pin value captured on the falling input clock edge |

## Verification
Direct results appear in the same cycle as their stimulus. The bench changes inputs 2 ns after a rising edge and checks 3 ns later. Registered and double-rate results belong to the rising edge after the inputs are applied. The bench therefore checks the high phase at 5 ns and the low phase at 15 ns after that edge, and compares each with the value its reference model has captured. For the falling-edge input tap, the model takes the pin level seen in the high phase, and the check falls in the low phase. External pin drivers change only away from clock edges. This keeps every checked level free of the edge at which it switches.

// File: rtl/bidir_ddr_cell.sv
module bidir_ddr_cell #(
  parameter int          OUT_MODE = 2,
  parameter int          OE_MODE  = 2,
  parameter logic [7:0]  INV_MASK = 8'h00
) (
  input  logic clk_out,
  input  logic clk_in,
  input  logic ce,
  input  logic rst,
  input  logic dout_a,
  input  logic dout_b,
  input  logic oe_a,
  input  logic oe_b,
  inout  wire  pad,
  output logic din_direct,
  output logic din_rise,
  output logic din_fall
);

  localparam int MODE_DIRECT = 0;
  localparam int MODE_REG    = 1;

  logic oclk, iclk, ce_i, rst_i, da_i, db_i, ta_i, tb_i;
  logic oq_a, oq_b, tq_a, tq_b;
  logic out_lvl, en_lvl;

  assign {rst_i, ce_i, iclk, oclk, tb_i, ta_i, db_i, da_i} =
    {rst, ce, clk_in, clk_out, oe_b, oe_a, dout_b, dout_a} ^ INV_MASK;

  function automatic logic pick(input int mode, input logic d, input logic qa,
                                input logic qb, input logic hi);
    if (mode == MODE_DIRECT) return d;
    if (mode == MODE_REG)    return qa;
    return hi ? qa : qb;
  endfunction

  always_ff @(posedge oclk or posedge rst_i) begin
    if (rst_i) begin
      oq_a <= 1'b0;
      oq_b <= 1'b0;
      tq_a <= 1'b1;
      tq_b <= 1'b1;
    end else if (ce_i) begin
      oq_a <= da_i;
      oq_b <= db_i;
      tq_a <= ta_i;
      tq_b <= tb_i;
    end
  end

  always_ff @(posedge iclk or posedge rst_i) begin
    if (rst_i)     din_rise <= 1'b0;
    else if (ce_i) din_rise <= pad;
  end

  always_ff @(negedge iclk or posedge rst_i) begin
    if (rst_i)     din_fall <= 1'b0;
    else if (ce_i) din_fall <= pad;
  end

  assign out_lvl    = pick(OUT_MODE, da_i, oq_a, oq_b, oclk);
  assign en_lvl     = pick(OE_MODE, ta_i, tq_a, tq_b, oclk);
  assign pad        = en_lvl ? 1'bz : out_lvl;
  assign din_direct = pad;

  a_r8_reset_values: assert property (@(posedge oclk) disable iff (rst_i)
    $fell(rst_i) |-> (oq_a == 1'b0 && oq_b == 1'b0 && tq_a == 1'b1 && tq_b == 1'b1));

  a_r7_hold: assert property (@(posedge oclk) disable iff (rst_i)
    !ce_i |=> $stable({oq_a, oq_b, tq_a, tq_b}));

  a_r3_capture_pair: assert property (@(posedge oclk) disable iff (rst_i)
    ce_i |=> (oq_a == $past(da_i) && oq_b == $past(db_i)));

  a_r5_enable_capture: assert property (@(posedge oclk) disable iff (rst_i)
    ce_i |=> (tq_a == $past(ta_i) && tq_b == $past(tb_i)));

  generate
    if (OUT_MODE == MODE_DIRECT && OE_MODE == MODE_DIRECT) begin : g_in_chk
      a_r6_rise_tap: assert property (@(posedge iclk) disable iff (rst_i)
        ce_i |=> din_rise == $past(pad));
    end
  endgenerate

endmodule

// File: tb/bidir_ddr_cell_test.sv
`timescale 1ns/1ps
module bidir_ddr_cell_test;

  localparam int NI = 10;
  localparam int NCYC = 2000;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic ce = 1'b0;
  logic dout_a = 1'b0, dout_b = 1'b0, oe_a = 1'b1, oe_b = 1'b1;
  logic [NI-1:0] tb_en = '0;
  logic [NI-1:0] tb_val = '0;
  logic [NI-1:0] ddir, drise, dfall;
  logic [NI-1:0] ep;

  int checks = 0;
  int errors = 0;

  logic q_a = 1'b0, q_b = 1'b0, t_a = 1'b1, t_b = 1'b1, ir = 1'b0, ifl = 1'b0;
  logic pad0_hi = 1'b0, pad0_lo = 1'b0;

  always #10 clk = ~clk;

  function automatic int om(input int i);
    return (i == 9) ? 2 : i % 3;
  endfunction

  function automatic int oem(input int i);
    return (i == 9) ? 2 : i / 3;
  endfunction

  function automatic logic lvl(input int m, input logic d, input logic qa,
                               input logic qb, input logic hi);
    if (m == 0) return d;
    if (m == 1) return qa;
    return hi ? qa : qb;
  endfunction

  function automatic string tag(input int i, input logic en);
    if (i == 9) return "R9";
    if (rst)    return "R8";
    if (!ce)    return "R7";
    if (en)     return (oem(i) == 0) ? "R4" : "R5";
    if (om(i) == 0) return "R1";
    if (om(i) == 1) return "R2";
    return "R3";
  endfunction

  for (genvar g = 0; g < NI; g++) begin : gen
    localparam logic [7:0] IM = (g == 9) ? 8'hFF : 8'h00;
    wire [7:0] v = {rst, ce, clk, clk, oe_b, oe_a, dout_b, dout_a} ^ IM;
    wire pw;
    assign pw = tb_en[g] ? tb_val[g] : 1'bz;
    bidir_ddr_cell #(.OUT_MODE(om(g)), .OE_MODE(oem(g)), .INV_MASK(IM)) uut (
      .clk_out(v[4]), .clk_in(v[5]), .ce(v[6]), .rst(v[7]),
      .dout_a(v[0]), .dout_b(v[1]), .oe_a(v[2]), .oe_b(v[3]),
      .pad(pw), .din_direct(ddir[g]), .din_rise(drise[g]), .din_fall(dfall[g]));
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_phase(input logic hi, input logic i0_only_keep);
    for (int i = 0; i < NI; i++) begin
      logic en;
      logic o;
      en = lvl(oem(i), oe_a, t_a, t_b, hi);
      o  = lvl(om(i), dout_a, q_a, q_b, hi);
      if (en) begin
        tb_en[i]  = 1'b1;
        tb_val[i] = 1'($urandom);
        ep[i]     = tb_val[i];
      end else begin
        tb_en[i] = 1'b0;
        ep[i]    = o;
      end
    end
  endtask

  task automatic check_phase(input logic hi);
    for (int i = 0; i < NI; i++) begin
      logic en;
      en = lvl(oem(i), oe_a, t_a, t_b, hi);
      check(tag(i, en), ddir[i], ep[i]);
    end
  endtask

  task automatic release_others();
    for (int i = 1; i < NI; i++) tb_en[i] = 1'b0;
  endtask

  task automatic model_reset();
    q_a = 1'b0; q_b = 1'b0; t_a = 1'b1; t_b = 1'b1; ir = 1'b0; ifl = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd7));
    #1 rst = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      @(posedge clk);
      if (rst) model_reset();
      else if (ce) begin
        q_a = dout_a; q_b = dout_b; t_a = oe_a; t_b = oe_b; ir = pad0_lo;
      end
      #2;
      if (c < 3) begin
        rst = 1'b1; ce = 1'b1;
        dout_a = 1'b1; dout_b = 1'b1; oe_a = 1'b0; oe_b = 1'b0;
      end else if (c >= 50 && c < 60) begin
        rst = 1'b0; ce = 1'b1;
        dout_a = c[0]; dout_b = ~c[0]; oe_a = 1'b0; oe_b = 1'b0;
      end else if (c >= 60 && c < 70) begin
        rst = 1'b0; ce = 1'b1;
        dout_a = 1'b1; dout_b = 1'b0; oe_a = c[0]; oe_b = ~c[0];
      end else if (c >= 100 && c < 110) begin
        rst = 1'b0; ce = 1'b0;
        dout_a = 1'($urandom); dout_b = 1'($urandom);
        oe_a = 1'($urandom); oe_b = 1'($urandom);
      end else if (c >= 200 && c < 202) begin
        rst = 1'b1; ce = 1'b1;
      end else begin
        rst = (($urandom % 64) == 0);
        ce  = (($urandom % 8) != 0);
        dout_a = 1'($urandom); dout_b = 1'($urandom);
        oe_a = (($urandom % 4) == 0); oe_b = (($urandom % 4) == 0);
      end
      if (rst) model_reset();
      set_phase(1'b1, 1'b1);
      #3;
      if (c < 3) check("R8", drise[0], 1'b0);
      else check(rst ? "R8" : "R6", drise[0], ir);
      check_phase(1'b1);
      pad0_hi = ep[0];
      #3 release_others();
      #4;
      if (rst) ifl = 1'b0;
      else if (ce) ifl = pad0_hi;
      set_phase(1'b0, 1'b1);
      #3;
      check(rst ? "R8" : "R6", dfall[0], ifl);
      check_phase(1'b0);
      pad0_lo = ep[0];
      #3 release_others();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule